// File: doc/BRIEF.md
# Grouped Interrupt Aggregator

This block gathers up to 32 single-bit interrupt requests, one per general-purpose pin, and reduces them to one interrupt line for a processor interrupt controller. Each request is caught in a sticky source bit. A per-source enable mask selects which caught sources count. A block-level enable bit decides whether the group's combined request reaches the processor at all.

Software works through a small register bus. The enable mask is never written as a whole word. One register turns enable bits on where a 1 is written, and another turns them off where a 1 is written. This lets two handlers change different bits with no read-modify-write. Source bits are cleared by writing 1s to them. A handler reads the masked result register, writes that same value back to the source register, and so clears exactly the sources it is about to service.

Top module: `irq_group_agg`

## Requirements
- R1: After synchronous reset, all source bits, all enable bits and the block enable are 0, and `grp_irq` is 0.
- R2: A source bit becomes 1 at the first rising clock edge at which its `req_i` bit is 1. It stays 1 after the request returns to 0, until software clears it.
- R3: A write to address 1 (enable set) turns on every enable bit whose data bit is 1. Enable bits written with 0 keep their value.
- R4: A write to address 2 (enable clear) turns off every enable bit whose data bit is 1. Enable bits written with 0 keep their value.
- R5: A read of address 1 or address 2 returns the current enable mask.
- R6: A write to address 0 (source status) clears every source bit whose data bit is 1 and leaves the others unchanged. A read of address 0 returns the source bits.
- R7: If a request and a clearing write hit the same source bit at the same edge, the bit ends up 1.
- R8: A read of address 3 returns the source bits ANDed with the enable bits. Writes to address 3 change nothing.
- R9: `grp_irq` is a register. At each edge it takes the value of (block enable AND the OR of all result bits) as it stood just before that edge.
- R10: Bit 0 of address 4 holds the block enable. A read of address 4 returns it in bit 0, with all other bits 0. While it is 0, `grp_irq` is 0 one edge later, whatever the result bits are.
- R11: Addresses 5 to 7 read as 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 32 | Interrupt requests, one per source, sampled each edge |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the selected register |
| grp_irq | output | 1 | Registered group interrupt to the processor |

## Verification
The core masking function is driven with a table of request and enable patterns. The table covers disjoint masks, full masks and empty masks, a single top bit, mixed nibbles, and the block enable held off. Each row shows whether the result is a true bitwise AND and not a reduction. Each row also shows whether the group line follows both the mask and the block enable. Directed sequences then separate the two enable write ports and check the write-back-to-clear idiom. They check the case of a request and a clear landing in the same cycle, and the one-cycle lag of the group line. They also check that writes to read-only and unmapped addresses have no effect.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

    localparam int SRC_N  = 32;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_SRC    = 3'd0,
        RA_EN_SET = 3'd1,
        RA_EN_CLR = 3'd2,
        RA_RESULT = 3'd3,
        RA_BLK    = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic src_w1c;
        logic en_w1s;
        logic en_w1c;
        logic blk_wr;
    } wr_strobe_t;

    function automatic wr_strobe_t decode_write(logic sel, logic wr, logic [ADDR_W-1:0] addr);
        wr_strobe_t s;
        s = '0;
        if (sel && wr) begin
            case (addr)
                RA_SRC:    s.src_w1c = 1'b1;
                RA_EN_SET: s.en_w1s  = 1'b1;
                RA_EN_CLR: s.en_w1c  = 1'b1;
                RA_BLK:    s.blk_wr  = 1'b1;
                default:   s = '0;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/irqagg_decode.sv
module irqagg_decode
    import irqagg_pkg::*;
#(
    parameter int W = SRC_N
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      src_q,
    input  logic [W-1:0]      en_q,
    input  logic              blk_q,
    input  logic [W-1:0]      result,
    output wr_strobe_t        strobe,
    output logic [W-1:0]      rdata
);

    always_comb begin
        strobe = decode_write(bus_sel, bus_wr, bus_addr);
    end

    always_comb begin
        rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (bus_addr)
                RA_SRC:    rdata = src_q;
                RA_EN_SET: rdata = en_q;
                RA_EN_CLR: rdata = en_q;
                RA_RESULT: rdata = result;
                RA_BLK:    rdata = {{(W-1){1'b0}}, blk_q};
                default:   rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/irqagg_src_bank.sv
module irqagg_src_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] req_i,
    input  logic         clr_we,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] src_q
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic kill;
        assign kill = clr_we && clr_mask[i];
        always_ff @(posedge clk) begin
            if (rst) begin
                src_q[i] <= 1'b0;
            end else if (req_i[i]) begin
                src_q[i] <= 1'b1;      // a new event beats a same-cycle clear
            end else if (kill) begin
                src_q[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/irqagg_en_reg.sv
module irqagg_en_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic         blk_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] en_q,
    output logic         blk_q
);

    logic [W-1:0] set_m;
    logic [W-1:0] clr_m;

    assign set_m = set_we ? wdata : '0;
    assign clr_m = clr_we ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            blk_q <= 1'b0;
        end else begin
            en_q <= (en_q | set_m) & ~clr_m;
            if (blk_we) begin
                blk_q <= wdata[0];
            end
        end
    end

endmodule

// File: rtl/irqagg_out.sv
module irqagg_out #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] src_q,
    input  logic [W-1:0] en_q,
    input  logic         blk_q,
    output logic [W-1:0] result,
    output logic         grp_irq
);

    assign result = src_q & en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            grp_irq <= 1'b0;
        end else begin
            grp_irq <= blk_q && (|result);
        end
    end

endmodule

// File: rtl/irq_group_agg.sv
module irq_group_agg
    import irqagg_pkg::*;
#(
    parameter int W = SRC_N
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [W-1:0]      req_i,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    output logic              grp_irq
);

    wr_strobe_t   strobe;
    logic [W-1:0] src_q;
    logic [W-1:0] en_q;
    logic         blk_q;
    logic [W-1:0] result;

    irqagg_decode #(.W(W)) u_dec (
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .src_q    (src_q),
        .en_q     (en_q),
        .blk_q    (blk_q),
        .result   (result),
        .strobe   (strobe),
        .rdata    (bus_rdata)
    );

    irqagg_src_bank #(.W(W)) u_src (
        .clk      (clk),
        .rst      (rst),
        .req_i    (req_i),
        .clr_we   (strobe.src_w1c),
        .clr_mask (bus_wdata),
        .src_q    (src_q)
    );

    irqagg_en_reg #(.W(W)) u_en (
        .clk    (clk),
        .rst    (rst),
        .set_we (strobe.en_w1s),
        .clr_we (strobe.en_w1c),
        .blk_we (strobe.blk_wr),
        .wdata  (bus_wdata),
        .en_q   (en_q),
        .blk_q  (blk_q)
    );

    irqagg_out #(.W(W)) u_out (
        .clk     (clk),
        .rst     (rst),
        .src_q   (src_q),
        .en_q    (en_q),
        .blk_q   (blk_q),
        .result  (result),
        .grp_irq (grp_irq)
    );

endmodule

// File: rtl/irqagg_chk.sv
module irqagg_chk
    import irqagg_pkg::*;
#(
    parameter int W = SRC_N
) (
    input logic              clk,
    input logic              rst,
    input logic [W-1:0]      req_i,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [W-1:0]      bus_wdata,
    input logic [W-1:0]      bus_rdata,
    input logic              grp_irq,
    input logic [W-1:0]      src_q,
    input logic [W-1:0]      en_q,
    input logic              blk_q
);

    p_req_latched_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((src_q & $past(req_i)) == $past(req_i)));

    p_en_set_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && bus_addr == RA_EN_SET) |=>
        ((en_q & $past(bus_wdata)) == $past(bus_wdata)));

    p_en_clr_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && bus_addr == RA_EN_CLR) |=>
        ((en_q & $past(bus_wdata)) == '0));

    p_result_read_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && bus_addr == RA_RESULT) |->
        (bus_rdata == (src_q & en_q)));

    p_irq_follows_r9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (grp_irq == ($past(blk_q) && (|$past(src_q & en_q)))));

    p_blk_gates_r10: assert property (@(posedge clk) disable iff (rst)
        !blk_q |=> !grp_irq);

    p_unmapped_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && bus_addr > RA_BLK) |=> ($stable(en_q) && $stable(blk_q)));

endmodule

bind irq_group_agg irqagg_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_i     (req_i),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .grp_irq   (grp_irq),
    .src_q     (src_q),
    .en_q      (en_q),
    .blk_q     (blk_q)
);

// File: tb/sim_irq_group_agg.sv
`timescale 1ns/1ps
module sim_irq_group_agg;

    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [W-1:0]  req_i = '0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [2:0]    bus_addr = '0;
    logic [W-1:0]  bus_wdata = '0;
    logic [W-1:0]  bus_rdata;
    logic          grp_irq;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    irq_group_agg #(.W(W)) u0 (
        .clk(clk), .rst(rst), .req_i(req_i), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .grp_irq(grp_irq)
    );

    // row: request pattern, enable pattern, block enable, expected result, expected line
    typedef struct packed {
        logic [W-1:0] req;
        logic [W-1:0] en;
        logic         blk;
        logic [W-1:0] res;
        logic         irq;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{32'h0000_00F0, 32'h0000_0030, 1'b1, 32'h0000_0030, 1'b1},
        '{32'h8000_0001, 32'h0000_0001, 1'b0, 32'h0000_0001, 1'b0},
        '{32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 32'h0000_0000, 1'b0},
        '{32'h1234_5678, 32'hFFFF_0000, 1'b1, 32'h1234_0000, 1'b1},
        '{32'h0000_0000, 32'hFFFF_FFFF, 1'b1, 32'h0000_0000, 1'b0},
        '{32'hAAAA_AAAA, 32'h5555_5555, 1'b1, 32'h0000_0000, 1'b0},
        '{32'h8000_0000, 32'h8000_0000, 1'b1, 32'h8000_0000, 1'b1}
    };

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // all bus tasks are entered at a falling edge and return at a falling edge
    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic pulse(input logic [W-1:0] r);
        req_i = r;
        @(negedge clk);
        req_i = '0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [W-1:0] d;
        logic [W-1:0] res;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(3'd0, d); chk("R1 src", d, '0);
        rd(3'd1, d); chk("R1 en", d, '0);
        rd(3'd4, d); chk("R1 blk", d, '0);
        chk("R1 irq", {31'b0, grp_irq}, '0);

        // table walk: R8 masking and R9 line
        for (int i = 0; i < NV; i++) begin
            wr(3'd0, '1);
            wr(3'd2, '1);
            wr(3'd4, {31'b0, VEC[i].blk});
            pulse(VEC[i].req);
            wr(3'd1, VEC[i].en);
            rd(3'd3, d);
            chk($sformatf("R8 row%0d result", i), d, VEC[i].res);
            chk($sformatf("R9 row%0d irq", i), {31'b0, grp_irq}, {31'b0, VEC[i].irq});
        end

        // reset the state for the directed part
        wr(3'd0, '1); wr(3'd2, '1); wr(3'd4, '0);

        // R2 sticky source
        pulse(32'h0000_0008);
        repeat (3) @(negedge clk);
        rd(3'd0, d); chk("R2 sticky", d, 32'h0000_0008);
        wr(3'd0, 32'h0000_0008);

        // R3 set port, R5 readback on both addresses
        wr(3'd1, 32'h0000_000F);
        wr(3'd1, 32'h0000_00F0);
        rd(3'd1, d); chk("R3 set accum", d, 32'h0000_00FF);
        rd(3'd2, d); chk("R5 read clr addr", d, 32'h0000_00FF);

        // R4 clear port
        wr(3'd2, 32'h0000_000C);
        rd(3'd1, d); chk("R4 clr", d, 32'h0000_00F3);

        // R6 write back the result value
        pulse(32'h0000_00FF);
        rd(3'd3, res); chk("R6 result", res, 32'h0000_00F3);
        wr(3'd0, res);
        rd(3'd0, d); chk("R6 serviced only", d, 32'h0000_000C);

        // R7 request and clear at one edge
        req_i = 32'h0000_0001;
        wr(3'd0, 32'h0000_0001);
        req_i = '0;
        rd(3'd0, d); chk("R7 set wins", d, 32'h0000_000D);
        wr(3'd0, 32'h0000_0001);
        rd(3'd0, d); chk("R6 plain clear", d, 32'h0000_000C);

        // R8 write to result ignored
        wr(3'd1, 32'h0000_000C);
        wr(3'd3, '0);
        rd(3'd3, d); chk("R8 ro", d, 32'h0000_000C);

        // R10 gating and R9 lag
        repeat (2) @(negedge clk);
        chk("R10 off", {31'b0, grp_irq}, '0);
        wr(3'd4, 32'hFFFF_FFFE);
        rd(3'd4, d); chk("R10 bit0 only", d, '0);
        wr(3'd4, 32'hFFFF_FFFF);
        chk("R9 lag", {31'b0, grp_irq}, '0);
        @(negedge clk);
        chk("R9 on", {31'b0, grp_irq}, 32'd1);
        rd(3'd4, d); chk("R10 read", d, 32'd1);

        // R11 unmapped addresses
        wr(3'd5, '1);
        wr(3'd6, '1);
        wr(3'd7, '0);
        rd(3'd1, d); chk("R11 en kept", d, 32'h0000_00FF);
        rd(3'd0, d); chk("R11 src kept", d, 32'h0000_000C);
        rd(3'd4, d); chk("R11 blk kept", d, 32'd1);
        rd(3'd6, d); chk("R11 read zero", d, '0);

        finish_run();
    end

endmodule